// File: doc/BRIEF.md
# Clock-Control Configuration Slave on a Two-Wire Serial Bus

This block is a standard-mode two-wire serial bus slave that holds a small bank of clock-control configuration bytes. It oversamples the SCL and SDA lines on the system clock. It recognises START and STOP conditions, matches its 7-bit address and acknowledges the address byte. It then accepts a block write or returns a block read. The stored bytes drive the rest of the chip in parallel through `cfg_bytes`.

Every write has two leading bytes, a command byte and a count byte. Both are acknowledged and then thrown away. Data bytes follow and land from index 0 upward. A STOP after any complete byte ends the transfer, and bytes that were not reached keep their values. A read returns a byte count first, then the stored bytes in index order. One byte has a group of bits that reads back as the complement of what was written.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth clock) only the address byte whose upper seven bits equal 0x69, so 0xD2 for a write and 0xD3 for a read. With any other address it never drives SDA, and no stored byte changes.
- R2: In a write, the first two bytes after the address are acknowledged and their values discarded. Each following byte is acknowledged and stored, the first of them at index 0 and the rest at rising indices.
- R3: A STOP after any complete data byte ends the write. Bytes with higher indices keep their previous values, and a byte cut off before its eighth bit is not stored.
- R4: Data bytes beyond index 5 are acknowledged and discarded.
- R5: After reset, bytes 0 to 5 hold 0x07, 0xFF, 0xFF, 0x00, 0x00 and 0x00. Byte i appears on cfg_bytes[8i+7:8i], and SDA is released.
- R6: A read sends the value 6 first, then bytes 0 to 5, each most significant bit first. Each byte is followed by a host acknowledge slot.
- R7: Bits 6, 5 and 4 of byte 3 keep the written value on cfg_bytes but are sent inverted in a read.
- R8: When the host answers a read byte with NACK, the slave releases SDA and stays silent until STOP. The next transaction works normally.
- R9: The slave changes the level it drives on SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the slave pulls SDA low |
| cfg_bytes | output | 48 | Stored configuration bytes, byte i at bits 8i+7 to 8i |

## Verification
The bench builds the block with its default parameters: six stored bytes, a two-stage line synchroniser, address 0x69 and the complement mask 0x70 on byte 3. With only six bytes, the bench can stop a write after every possible data-byte count from zero to six and overflow it past the end. It reads the whole bank back after each case. The small address space also lets the bench offer all 128 seven-bit addresses, so every non-matching one is shown to be ignored.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_WAIT
    } slv_state_e;

    typedef struct packed {
        logic scl_s;
        logic sda_s;
        logic scl_rise;
        logic scl_fall;
        logic start_det;
        logic stop_det;
    } bus_evt_t;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h07;
            1, 2:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
    import cfg_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[SYNC_STAGES-1];
            sda_d    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    always_comb begin
        evt.scl_s     = scl_pipe[SYNC_STAGES-1];
        evt.sda_s     = sda_pipe[SYNC_STAGES-1];
        evt.scl_rise  = evt.scl_s & ~scl_d;
        evt.scl_fall  = ~evt.scl_s & scl_d;
        evt.start_det = evt.scl_s & scl_d & sda_d & ~evt.sda_s;
        evt.stop_det  = evt.scl_s & scl_d & ~sda_d & evt.sda_s;
    end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_i2c_pkg::*;
#(
    parameter int         NUM_REGS = 6,
    parameter int         INV_IDX  = 3,
    parameter logic [7:0] INV_MASK = 8'h70,
    localparam int        IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    logic [NUM_REGS-1:0][7:0] bank;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= reg_default(g);
            else if (wr_en && wr_idx == IDX_W'(g))
                bank[g] <= wr_data;
        end
        assign cfg_flat[g*8 +: 8] = bank[g];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_data = bank[i] ^ ((i == INV_IDX) ? INV_MASK : 8'h00);
        end
    end

    // R4: the controller never requests a store outside the bank
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    // R3: without a store request every stored byte holds its value
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_flat));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter int         NUM_REGS    = 6,
    parameter int         SYNC_STAGES = 2,
    parameter int         INV_IDX     = 3,
    parameter logic [7:0] INV_MASK    = 8'h70
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_bytes
);
    localparam int IDX_W   = $clog2(NUM_REGS);
    localparam int POS_MAX = NUM_REGS + 2;
    localparam int POS_W   = $clog2(POS_MAX + 1);

    bus_evt_t           evt;
    slv_state_e         state;
    logic [7:0]         shreg;
    logic [3:0]         bitcnt;
    logic [POS_W-1:0]   pos;
    logic               rw;
    logic               byte_full;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [IDX_W-1:0]   rd_idx;
    logic [7:0]         bank_rd;
    logic [7:0]         rd_byte;
    logic [POS_W-1:0]   pos_next;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    cfg_regbank #(
        .NUM_REGS (NUM_REGS),
        .INV_IDX  (INV_IDX),
        .INV_MASK (INV_MASK)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (shreg),
        .rd_idx   (rd_idx),
        .rd_data  (bank_rd),
        .cfg_flat (cfg_bytes)
    );

    assign byte_full = (bitcnt == 4'd8);
    assign pos_next  = (pos == POS_W'(POS_MAX)) ? pos : pos + POS_W'(1);
    assign wr_idx    = IDX_W'(pos - POS_W'(2));
    assign rd_idx    = IDX_W'(pos - POS_W'(1));

    // position 0 and 1 of a write are the discarded command and count bytes
    assign wr_en = (state == ST_WR) && !evt.start_det && !evt.stop_det &&
                   evt.scl_fall && byte_full &&
                   (pos >= POS_W'(2)) && (pos < POS_W'(POS_MAX));

    always_comb begin
        if (pos == '0)
            rd_byte = 8'(NUM_REGS);
        else if (pos <= POS_W'(NUM_REGS))
            rd_byte = bank_rd;
        else
            rd_byte = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            shreg  <= '0;
            bitcnt <= '0;
            pos    <= '0;
            rw     <= 1'b0;
        end else if (evt.start_det) begin
            state  <= ST_ADDR;
            sda_oe <= 1'b0;
            bitcnt <= '0;
            pos    <= '0;
        end else if (evt.stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WR: begin
                    if (evt.scl_rise && !byte_full) begin
                        shreg  <= {shreg[6:0], evt.sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.scl_fall && byte_full) begin
                        bitcnt <= '0;
                        if (state == ST_WR) begin
                            sda_oe <= 1'b1;
                            state  <= ST_WR_ACK;
                            pos    <= pos_next;
                        end else if (shreg[7:1] == SLAVE_ADDR) begin
                            sda_oe <= 1'b1;
                            rw     <= shreg[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state  <= ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        if (rw) begin
                            state  <= ST_RD;
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            pos    <= pos_next;
                        end else begin
                            state  <= ST_WR;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (evt.scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.scl_fall) begin
                        if (byte_full) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_RD_ACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (evt.scl_rise && evt.sda_s) begin
                        state <= ST_WAIT;
                    end else if (evt.scl_fall) begin
                        state  <= ST_RD;
                        shreg  <= rd_byte;
                        sda_oe <= ~rd_byte[7];
                        pos    <= pos_next;
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: the driven SDA level never moves while the sampled clock line is high
    assert_sda_low_scl_R9: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !evt.scl_s);

    // R8: once the slave has given up on a transfer it stays off the bus
    assert_silent_wait_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !sda_oe);

    // R1: a START always begins address collection from the first bit
    assert_start_addr_R1: assert property (@(posedge clk) disable iff (rst)
        evt.start_det |=> (state == ST_ADDR && bitcnt == 4'd0));

    // R2: the data line is held low for the whole write acknowledge slot
    assert_write_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_ACK) |-> sda_oe);

endmodule

// File: tb/cfg_i2c_slave_bench.sv
`timescale 1ns/1ps
module cfg_i2c_slave_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [47:0] cfg_bytes;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int r9_viol = 0;
    bit done = 0;
    logic [7:0] exp_b [6];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    cfg_i2c_slave u_cfg_i2c_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .cfg_bytes (cfg_bytes)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [47:0] exp_flat();
        logic [47:0] f;
        for (int i = 0; i < 6; i++) f[i*8 +: 8] = exp_b[i];
        return f;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic bit_tx(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bit_rx(input logic drive, output logic b);
        sda_m = drive; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_tx(v[i]);
        bit_rx(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_rx(1'b1, s);
            v[i] = s;
        end
        bit_rx(~give_ack, s);
    endtask

    // write with ndata data bytes, optionally followed by a cut-off byte of 4 bits
    task automatic wr_txn(input int ndata, input int seed, input bit partial);
        logic a;
        bit all_ack = 1;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD2, a); all_ack &= a;
        send_byte(8'h3C ^ 8'(seed), a); all_ack &= a;
        send_byte(8'hC3 + 8'(seed), a); all_ack &= a;
        for (int i = 0; i < ndata; i++) begin
            d = 8'((seed * 37 + i * 53 + 11) % 256);
            send_byte(d, a); all_ack &= a;
            if (i < 6) exp_b[i] = d;
        end
        if (partial) for (int k = 0; k < 4; k++) bit_tx(1'b0);
        bus_stop();
        chk(all_ack, ndata > 6 ? "R4 ack past last byte" : "R2 every write byte acked", 64'(all_ack), 64'd1);
        chk(cfg_bytes == exp_flat(), partial ? "R3 cut-off byte dropped" : "R2/R3 stored bytes",
            64'(cfg_bytes), 64'(exp_flat()));
    endtask

    task automatic rd_txn(input string tag);
        logic a;
        logic [7:0] v;
        logic [7:0] e;
        bus_start();
        send_byte(8'hD3, a);
        chk(a, "R1 read address acked", 64'(a), 64'd1);
        recv_byte(1'b1, v);
        chk(v == 8'd6, "R6 byte count first", 64'(v), 64'd6);
        for (int i = 0; i < 6; i++) begin
            recv_byte(i != 5, v);
            e = exp_b[i] ^ ((i == 3) ? 8'h70 : 8'h00);
            chk(v == e, (i == 3) ? "R7 inverted read-back" : tag, 64'(v), 64'(e));
        end
        bus_stop();
    endtask

    initial begin : r9_mon
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && sda_oe != prev && scl_m) r9_viol++;
            prev = sda_oe;
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic a;
        logic [7:0] v;
        exp_b[0] = 8'h07; exp_b[1] = 8'hFF; exp_b[2] = 8'hFF;
        exp_b[3] = 8'h00; exp_b[4] = 8'h00; exp_b[5] = 8'h00;
        wq(5);
        rst = 1'b0;
        wq(4);
        chk(cfg_bytes == 48'h0000_00FF_FF07, "R5 reset defaults", 64'(cfg_bytes), 64'h0000_00FF_FF07);
        chk(sda_oe == 1'b0, "R5 SDA released", 64'(sda_oe), 64'd0);
        rd_txn("R6 default read-back");

        // R1: every other address is ignored
        for (int ad = 0; ad < 128; ad++) begin
            if (ad == 'h69) continue;
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            send_byte(8'h00, v[0]);
            bus_stop();
            chk(!a && !v[0], "R1 foreign address ignored", 64'(ad), 64'h69);
        end
        chk(cfg_bytes == exp_flat(), "R1 no store on foreign address", 64'(cfg_bytes), 64'(exp_flat()));

        // R2/R3: stop after each possible data-byte count
        for (int n = 0; n <= 6; n++) begin
            wr_txn(n, n + 1, 1'b0);
            rd_txn("R2 written byte read back");
        end
        wr_txn(2, 40, 1'b1);
        wr_txn(8, 77, 1'b0);
        rd_txn("R4 overflow discarded");

        // R7: all ones and all zeros into byte 3
        for (int p = 0; p < 2; p++) begin
            bus_start();
            send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
            for (int i = 0; i < 4; i++) begin
                v = (p == 0) ? 8'hFF : 8'h00;
                send_byte(v, a);
                exp_b[i] = v;
            end
            bus_stop();
            chk(cfg_bytes[31:24] == exp_b[3], "R7 stored value unchanged", 64'(cfg_bytes[31:24]), 64'(exp_b[3]));
            rd_txn("R7 read after pattern");
        end

        // R8: NACK after the count, slave must stay silent
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b0, v);
        chk(v == 8'd6, "R8 count before NACK", 64'(v), 64'd6);
        recv_byte(1'b1, v);
        chk(v == 8'hFF, "R8 SDA released after NACK", 64'(v), 64'hFF);
        bus_stop();
        rd_txn("R8 next read after NACK");

        chk(r9_viol == 0, "R9 SDA moves only with SCL low", 64'(r9_viol), 64'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule